// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block turns a 64-bit device DMA address into a physical page frame. It walks a region table, then a segment table, then a page table, all held in memory. It serves one function at a time. The translation settings come in as inputs: a table-origin value and an inclusive window given by a lower and an upper bound.

It accepts one request at a time and holds `req_ready_o` low until it has answered. Before it reads memory it runs three checks. A fixed interrupt-notification address passes through untranslated. A zero origin is rejected. An address outside the window is rejected. When these checks pass, the walker issues up to three 64-bit reads over a plain valid/ready request port with a response strobe. It checks the type field of the region entry and of the segment entry. Each result leaves as a one-cycle response.

Every failure raises an error-event pulse with a code. It also sets two sticky per-function flags: error state and store blocked. Both flags stay set until reset.

Top module: `dma_xlate_walker`

## Requirements
- R1: A request whose address equals `MSI_ADDR` (default 0xFEE0_0000) is answered without any memory read, even when the origin is zero. The response has `rsp_msi_o`=1, `rsp_addr_o` equal to the request address, `rsp_mask_o`=0xFFF, `rsp_perm_o`=1 and `rsp_err_o`=0.
- R2: Any other request made while `origin_i` is zero fails with event code 1 (invalid address space). It issues no memory read. This check takes precedence over the window check.
- R3: A request below `win_base_i` or above `win_limit_i` fails with event code 2 (out of range) and issues no memory read. Both bounds are inclusive.
- R4: The walk reads at three addresses, each 8-byte aligned:
  - the region entry at (`origin_i` with bits [11:0] cleared) + addr[52:42]*8;
  - the segment entry at (region entry with bits [11:0] cleared) + addr[41:31]*8;
  - the page entry at (segment entry with bits [11:0] cleared) + addr[19:12]*8.
- R5: Bits [3:2] of the region entry must equal 2'b11, and bits [3:2] of the segment entry must equal 2'b10. On a mismatch the walk stops with no further read and fails with event code 3, qualifier set.
- R6: A page entry of all zeros fails with event code 3, qualifier set.
- R7: A successful walk returns `rsp_addr_o` = page entry with bits [11:0] cleared, `rsp_mask_o`=0xFFF and `rsp_err_o`=0. `rsp_perm_o` is 0 when bit 10 (invalid) of the page entry is set, and 1 otherwise.
- R8: A failed request returns `rsp_err_o`=1, `rsp_addr_o`=0, `rsp_mask_o` all ones and `rsp_perm_o`=0. In the same cycle `evt_valid_o` pulses with `evt_code_o`, `evt_addr_o` equal to the request address, and `evt_qual_o` set only for code 3.
- R9: Any failure sets both `err_state_o` and `store_blocked_o`, visible in the cycle of the failing response. Both stay set through later successful requests until reset.
- R10: Only one request is outstanding at a time. `req_ready_o` is low from acceptance through the response cycle, and requests presented meanwhile are ignored. A memory request is held stable until accepted.
- R11: After reset, `req_ready_o`=1 and the response, event, memory-request and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 64 | DMA address to translate |
| req_ready_o | output | 1 | Walker idle, request accepted |
| origin_i | input | 64 | Table-origin value; low 12 bits are flags |
| win_base_i | input | 64 | Lowest allowed DMA address |
| win_limit_i | input | 64 | Highest allowed DMA address |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_addr_o | output | 64 | Memory read address |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 64 | Read data |
| rsp_valid_o | output | 1 | Result strobe, one cycle |
| rsp_addr_o | output | 64 | Translated frame or pass-through address |
| rsp_mask_o | output | 64 | Address mask of the result |
| rsp_err_o | output | 1 | Translation failed |
| rsp_perm_o | output | 1 | Access permitted |
| rsp_msi_o | output | 1 | Routed to the interrupt notification target |
| evt_valid_o | output | 1 | Error-event request |
| evt_code_o | output | 2 | 1 bad space, 2 out of range, 3 walk failure |
| evt_addr_o | output | 64 | Faulting DMA address |
| evt_qual_o | output | 1 | Qualifier bit of the event |
| err_state_o | output | 1 | Sticky error-state flag |
| store_blocked_o | output | 1 | Sticky store-blocked flag |

## Verification
Requests are run against a bench memory that holds a small table tree.

- The successful walk is tried with the invalid bit both clear and set. This shows that the permission comes from the page entry and not from the path.
- Three distinct walk failures stop at three different depths: region type, segment type, and a zero page entry. The logged read addresses show that the walk stops at the right depth.
- A window collapsed to a single address tells inclusive bounds apart from exclusive ones.
- A zero origin combined with an out-of-window address, and with the notification address, pins the check precedence.
- A request held during a busy walk, and a memory port that inserts stalls, show that exactly one response and a stable read request are produced.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  typedef enum logic [1:0] {
    EVT_NONE      = 2'd0,
    EVT_BAD_SPACE = 2'd1,
    EVT_RANGE     = 2'd2,
    EVT_WALK      = 2'd3
  } evt_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_state_e;

  localparam int unsigned LEVELS = 3;
endpackage

// File: rtl/dma_xlate_precheck.sv
module dma_xlate_precheck
  import dma_xlate_pkg::*;
#(
  parameter int unsigned   AW       = 64,
  parameter logic [AW-1:0] MSI_ADDR = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] origin_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic          msi_o,
  output logic          fail_o,
  output evt_code_e     code_o
);
  always_comb begin
    msi_o  = (addr_i == MSI_ADDR);
    fail_o = 1'b0;
    code_o = EVT_NONE;
    if (!msi_o) begin
      if (origin_i == '0) begin
        fail_o = 1'b1;
        code_o = EVT_BAD_SPACE;
      end else if ((addr_i < base_i) || (addr_i > limit_i)) begin
        fail_o = 1'b1;
        code_o = EVT_RANGE;
      end
    end
  end
endmodule

// File: rtl/dma_xlate_index.sv
module dma_xlate_index #(
  parameter int unsigned AW       = 64,
  parameter int unsigned RX_SHIFT = 42,
  parameter int unsigned RX_W     = 11,
  parameter int unsigned SX_SHIFT = 31,
  parameter int unsigned SX_W     = 11,
  parameter int unsigned PX_SHIFT = 12,
  parameter int unsigned PX_W     = 8
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] table_i,
  input  logic [1:0]    level_i,
  output logic [AW-1:0] entry_addr_o
);
  localparam int unsigned SHIFT [3] = '{RX_SHIFT, SX_SHIFT, PX_SHIFT};
  localparam int unsigned WIDTH [3] = '{RX_W, SX_W, PX_W};
  localparam int unsigned ENTRY_SH  = 3;

  logic [AW-1:0] idx [3];
  logic [AW-1:0] sel;

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    localparam logic [AW-1:0] FMASK = (AW'(1) << WIDTH[g]) - AW'(1);
    assign idx[g] = (vaddr_i >> SHIFT[g]) & FMASK;
  end

  always_comb begin
    case (level_i)
      2'd0:    sel = idx[0];
      2'd1:    sel = idx[1];
      default: sel = idx[2];
    endcase
    entry_addr_o = table_i + (sel << ENTRY_SH);
  end
endmodule

// File: rtl/dma_xlate_entry.sv
module dma_xlate_entry #(
  parameter int unsigned AW         = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned TYPE_LSB   = 2,
  parameter logic [1:0]  RT_TYPE    = 2'b11,
  parameter logic [1:0]  ST_TYPE    = 2'b10,
  parameter int unsigned INV_BIT    = 10
) (
  input  logic [AW-1:0] data_i,
  input  logic [1:0]    level_i,
  output logic [AW-1:0] frame_o,
  output logic          last_o,
  output logic          fault_o,
  output logic          perm_o
);
  localparam logic [AW-1:0] OFS_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);

  logic [1:0] ty;
  assign ty      = data_i[TYPE_LSB +: 2];
  assign frame_o = data_i & ~OFS_MASK;
  assign last_o  = (level_i == 2'd2);
  assign perm_o  = ~data_i[INV_BIT];

  always_comb begin
    case (level_i)
      2'd0:    fault_o = (ty != RT_TYPE);
      2'd1:    fault_o = (ty != ST_TYPE);
      default: fault_o = (data_i == '0);
    endcase
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import dma_xlate_pkg::*;
#(
  parameter int unsigned   AW         = 64,
  parameter logic [AW-1:0] MSI_ADDR   = 64'h0000_0000_FEE0_0000,
  parameter int unsigned   RX_SHIFT   = 42,
  parameter int unsigned   RX_W       = 11,
  parameter int unsigned   SX_SHIFT   = 31,
  parameter int unsigned   SX_W       = 11,
  parameter int unsigned   PX_SHIFT   = 12,
  parameter int unsigned   PX_W       = 8,
  parameter int unsigned   PAGE_SHIFT = 12,
  parameter int unsigned   TYPE_LSB   = 2,
  parameter logic [1:0]    RT_TYPE    = 2'b11,
  parameter logic [1:0]    ST_TYPE    = 2'b10,
  parameter int unsigned   INV_BIT    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] origin_i,
  input  logic [AW-1:0] win_base_i,
  input  logic [AW-1:0] win_limit_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic [AW-1:0] rsp_mask_o,
  output logic          rsp_err_o,
  output logic          rsp_perm_o,
  output logic          rsp_msi_o,
  output logic          evt_valid_o,
  output logic [1:0]    evt_code_o,
  output logic [AW-1:0] evt_addr_o,
  output logic          evt_qual_o,
  output logic          err_state_o,
  output logic          store_blocked_o
);
  localparam logic [AW-1:0] OFS_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);
  localparam logic [1:0]    LAST_LVL = 2'(LEVELS - 1);

  walk_state_e   state_q;
  logic [1:0]    level_q;
  logic [AW-1:0] vaddr_q, table_q, res_addr_q;
  logic          res_err_q, res_perm_q, res_msi_q;
  evt_code_e     res_code_q;
  logic          err_flag_q, blk_flag_q;

  logic          pre_msi, pre_fail;
  evt_code_e     pre_code;
  logic [AW-1:0] ent_frame;
  logic          ent_last, ent_fault, ent_perm;

  dma_xlate_precheck #(.AW(AW), .MSI_ADDR(MSI_ADDR)) u_pre (
    .addr_i  (req_addr_i),
    .origin_i(origin_i),
    .base_i  (win_base_i),
    .limit_i (win_limit_i),
    .msi_o   (pre_msi),
    .fail_o  (pre_fail),
    .code_o  (pre_code)
  );

  dma_xlate_index #(
    .AW(AW), .RX_SHIFT(RX_SHIFT), .RX_W(RX_W), .SX_SHIFT(SX_SHIFT), .SX_W(SX_W),
    .PX_SHIFT(PX_SHIFT), .PX_W(PX_W)
  ) u_idx (
    .vaddr_i     (vaddr_q),
    .table_i     (table_q),
    .level_i     (level_q),
    .entry_addr_o(mem_req_addr_o)
  );

  dma_xlate_entry #(
    .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .TYPE_LSB(TYPE_LSB), .RT_TYPE(RT_TYPE),
    .ST_TYPE(ST_TYPE), .INV_BIT(INV_BIT)
  ) u_ent (
    .data_i (mem_rsp_data_i),
    .level_i(level_q),
    .frame_o(ent_frame),
    .last_o (ent_last),
    .fault_o(ent_fault),
    .perm_o (ent_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      level_q    <= '0;
      vaddr_q    <= '0;
      table_q    <= '0;
      res_addr_q <= '0;
      res_err_q  <= 1'b0;
      res_perm_q <= 1'b0;
      res_msi_q  <= 1'b0;
      res_code_q <= EVT_NONE;
      err_flag_q <= 1'b0;
      blk_flag_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q    <= req_addr_i;
          level_q    <= '0;
          table_q    <= origin_i & ~OFS_MASK;
          res_msi_q  <= pre_msi;
          res_code_q <= pre_code;
          res_err_q  <= pre_fail;
          res_perm_q <= pre_msi;
          res_addr_q <= pre_msi ? req_addr_i : '0;
          if (pre_fail) begin
            err_flag_q <= 1'b1;
            blk_flag_q <= 1'b1;
          end
          state_q <= (pre_msi || pre_fail) ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (ent_fault) begin
            res_err_q  <= 1'b1;
            res_code_q <= EVT_WALK;
            res_perm_q <= 1'b0;
            res_addr_q <= '0;
            err_flag_q <= 1'b1;
            blk_flag_q <= 1'b1;
            state_q    <= ST_RESP;
          end else if (ent_last) begin
            res_err_q  <= 1'b0;
            res_addr_q <= ent_frame;
            res_perm_q <= ent_perm;
            state_q    <= ST_RESP;
          end else begin
            table_q <= ent_frame;
            level_q <= (level_q == LAST_LVL) ? level_q : level_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_addr_o      = res_addr_q;
  assign rsp_mask_o      = res_err_q ? '1 : OFS_MASK;
  assign rsp_err_o       = res_err_q;
  assign rsp_perm_o      = res_perm_q;
  assign rsp_msi_o       = res_msi_q;
  assign evt_valid_o     = rsp_valid_o && res_err_q;
  assign evt_code_o      = res_code_q;
  assign evt_addr_o      = vaddr_q;
  assign evt_qual_o      = (res_code_q == EVT_WALK);
  assign err_state_o     = err_flag_q;
  assign store_blocked_o = blk_flag_q;
endmodule

// File: rtl/dma_xlate_walker_chk.sv
module dma_xlate_walker_chk #(
  parameter int unsigned AW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          mem_req_valid_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_req_ready_i,
  input logic          rsp_valid_o,
  input logic [AW-1:0] rsp_mask_o,
  input logic          rsp_err_o,
  input logic          rsp_msi_o,
  input logic          evt_valid_o,
  input logic          err_state_o,
  input logic          store_blocked_o
);
  assert_msi_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_msi_o |-> !rsp_err_o && rsp_mask_o == AW'(4095));
  assert_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000);
  assert_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> rsp_valid_o && rsp_mask_o == '1);
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_state_o |=> err_state_o && store_blocked_o);
  assert_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_state_o) |-> rsp_valid_o && rsp_err_o);
  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  assert_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o);
endmodule

bind dma_xlate_walker dma_xlate_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dma_xlate_walker.sv
module sim_dma_xlate_walker;
  localparam logic [63:0] MSI = 64'h0000_0000_FEE0_0000;
  localparam logic [63:0] OFS = 64'hFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [63:0] req_addr = '0, origin = '0, wbase = '0, wlimit = '0;
  logic        mreq_valid, mreq_ready = 1'b1, mrsp_valid = 1'b0;
  logic [63:0] mreq_addr, mrsp_data = '0;
  logic        rsp_valid, rsp_err, rsp_perm, rsp_msi, evt_valid, evt_qual, err_st, st_blk;
  logic [63:0] rsp_addr, rsp_mask, evt_addr;
  logic [1:0]  evt_code;

  dma_xlate_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .origin_i(origin), .win_base_i(wbase), .win_limit_i(wlimit),
    .mem_req_valid_o(mreq_valid), .mem_req_addr_o(mreq_addr), .mem_req_ready_i(mreq_ready),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_mask_o(rsp_mask),
    .rsp_err_o(rsp_err), .rsp_perm_o(rsp_perm), .rsp_msi_o(rsp_msi),
    .evt_valid_o(evt_valid), .evt_code_o(evt_code), .evt_addr_o(evt_addr),
    .evt_qual_o(evt_qual), .err_state_o(err_st), .store_blocked_o(st_blk)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic [63:0] mask;
    logic [63:0] va;
    logic        err, perm, msi, qual, flag;
    logic [1:0]  code;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] rd_q[$];
  logic [63:0] mem [logic [63:0]];
  int checks = 0, fails = 0, rsp_cnt = 0, cyc = 0;
  bit flag_m = 0, stall = 0, pend = 0;
  logic [63:0] pdata = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic predict(input logic [63:0] a, output exp_t e);
    logic [63:0] ea, v;
    logic [1:0] c;
    e = '0;
    e.va = a;
    c = 2'd0;
    if (a == MSI) begin
      e.addr = a; e.mask = OFS; e.perm = 1; e.msi = 1;
    end else if (origin == 0) c = 2'd1;
    else if (a < wbase || a > wlimit) c = 2'd2;
    else begin
      ea = (origin & ~OFS) + {50'd0, a[52:42], 3'b000};
      rd_q.push_back(ea); v = rd(ea);
      if (v[3:2] != 2'b11) c = 2'd3;
      else begin
        ea = (v & ~OFS) + {50'd0, a[41:31], 3'b000};
        rd_q.push_back(ea); v = rd(ea);
        if (v[3:2] != 2'b10) c = 2'd3;
        else begin
          ea = (v & ~OFS) + {53'd0, a[19:12], 3'b000};
          rd_q.push_back(ea); v = rd(ea);
          if (v == 0) c = 2'd3;
          else begin
            e.addr = v & ~OFS; e.mask = OFS; e.perm = ~v[10];
          end
        end
      end
    end
    if (c != 0) begin
      e.err = 1; e.code = c; e.mask = '1; e.addr = 0; e.perm = 0; e.qual = (c == 2'd3);
      flag_m = 1;
    end
    e.flag = flag_m;
  endtask

  // memory model: response two edges after the accepting edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mrsp_valid <= 1'b0;
    if (pend) begin
      mrsp_valid <= 1'b1;
      mrsp_data  <= pdata;
      pend       <= 0;
    end
    if (mreq_valid && mreq_ready) begin
      pend  <= 1;
      pdata <= rd(mreq_addr);
    end
    mreq_ready <= stall ? ((cyc % 3) != 0) : 1'b1;
  end

  // read-address checker and response monitor
  always @(negedge clk) begin
    if (rst_n && mreq_valid && mreq_ready) begin
      if (rd_q.size() == 0) chk(0, "R4 unexpected read", mreq_addr, 0);
      else begin
        logic [63:0] ex;
        ex = rd_q.pop_front();
        chk(mreq_addr == ex, "R4 read address", mreq_addr, ex);
      end
    end
    if (rst_n && rsp_valid) begin
      rsp_cnt++;
      if (exp_q.size() == 0) chk(0, "R10 extra response", rsp_addr, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_err == e.err, "R8 rsp_err", 64'(rsp_err), 64'(e.err));
        chk(rsp_addr == e.addr, "R7 rsp_addr", rsp_addr, e.addr);
        chk(rsp_mask == e.mask, "R7 rsp_mask", rsp_mask, e.mask);
        chk(rsp_perm == e.perm, "R7 rsp_perm", 64'(rsp_perm), 64'(e.perm));
        chk(rsp_msi == e.msi, "R1 rsp_msi", 64'(rsp_msi), 64'(e.msi));
        chk(evt_valid == e.err, "R8 evt_valid", 64'(evt_valid), 64'(e.err));
        if (e.err) begin
          chk(evt_code == e.code, "R2 R3 R5 R6 evt_code", 64'(evt_code), 64'(e.code));
          chk(evt_qual == e.qual, "R5 evt_qual", 64'(evt_qual), 64'(e.qual));
          chk(evt_addr == e.va, "R8 evt_addr", evt_addr, e.va);
        end
        chk(err_st == e.flag, "R9 err_state", 64'(err_st), 64'(e.flag));
        chk(st_blk == e.flag, "R9 store_blocked", 64'(st_blk), 64'(e.flag));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog R10 act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(rd_q.size() == 0, "R4 reads issued", 64'(rd_q.size()), 0);
  endtask

  task automatic send(input logic [63:0] a);
    exp_t e;
    predict(a, e);
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    wait_done();
  endtask

  // holds a second request while busy; it must be ignored
  task automatic send_busy(input logic [63:0] a, input logic [63:0] junk);
    exp_t e;
    int n0;
    predict(a, e);
    exp_q.push_back(e);
    n0 = rsp_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_addr = junk;
    while (exp_q.size() != 0) @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk(rsp_cnt == n0 + 1, "R10 single response", 64'(rsp_cnt - n0), 1);
  endtask

  localparam logic [63:0] A1 = (64'd3 << 42) | (64'd5 << 31) | (64'd7 << 12) | 64'h123;
  localparam logic [63:0] A2 = (64'd3 << 42) | (64'd5 << 31) | (64'd9 << 12);
  localparam logic [63:0] A3 = (64'd4 << 42) | (64'd5 << 31) | (64'd7 << 12);
  localparam logic [63:0] A4 = (64'd3 << 42) | (64'd6 << 31) | (64'd7 << 12);
  localparam logic [63:0] A5 = (64'd3 << 42) | (64'd5 << 31) | (64'd10 << 12);

  initial begin
    mem[64'h10000 + 3*8]  = 64'h20000 | 64'hC;
    mem[64'h10000 + 4*8]  = 64'h20000 | 64'h8;
    mem[64'h20000 + 5*8]  = 64'h30000 | 64'h8;
    mem[64'h20000 + 6*8]  = 64'h30000 | 64'hC;
    mem[64'h30000 + 7*8]  = 64'hABCD_E003;
    mem[64'h30000 + 9*8]  = 64'h1234_5400;
    origin = 64'h10005; wbase = 0; wlimit = 64'h001F_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1, "R11 ready", 64'(req_ready), 1);
    chk(rsp_valid == 0 && evt_valid == 0, "R11 rsp/evt", 64'(rsp_valid), 0);
    chk(mreq_valid == 0, "R11 mem_req", 64'(mreq_valid), 0);
    chk(err_st == 0 && st_blk == 0, "R11 flags", 64'(err_st), 0);
    rst_n = 1;
    send(A1);            // R4 R7 success
    send(A2);            // R7 invalid bit -> no permission
    stall = 1;
    send(A1);            // R10 stalled memory port
    send(MSI);           // R1
    send(A3);            // R5 region type
    send(A4);            // R5 segment type
    stall = 0;
    send(A5);            // R6 zero page entry
    send(A1);            // R9 flags stay
    wbase = A1; wlimit = A1;
    send(A1);            // R3 inclusive bound
    send(A1 + 1);        // R3 above
    send(A1 - 1);        // R3 below
    origin = 0;
    send(A1 + 1);        // R2 precedence over range
    send(MSI);           // R1 with zero origin
    origin = 64'h10005; wbase = 0; wlimit = 64'h001F_FFFF_FFFF_FFFF;
    send_busy(A1, MSI);  // R10
    rst_n = 0; flag_m = 0;
    @(negedge clk);
    chk(err_st == 0 && st_blk == 0, "R9 cleared by reset", 64'(err_st), 0);
    rst_n = 1;
    send(A2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule